// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This block turns a system clock into CAN bit timing. A prescaler cuts the clock into time quanta. Each bit is made of a one-quantum synchronization segment, a programmable first phase segment and a programmable second phase segment. The unit raises a one-cycle `bit_start` strobe when a bit begins and a one-cycle `sample_stb` strobe with the sampled value `sample_val` at the point between the two phase segments. It watches the receive line for recessive-to-dominant (1 to 0) edges. In idle it hard-synchronizes on such an edge. During a frame it moves the bit boundary by at most the programmed jump width.

All timing fields sit in one 16-bit configuration word. That word can be changed only while the unit is in reset mode. Reset mode is entered on hardware reset, on a bus-off indication or on a software request. Leaving reset mode starts the prescaler and puts the segment machine into idle. The receive line is assumed to be synchronous to `clk` already. It is looked at once per quantum, at the clock edge that ends the quantum, so phase errors are resolved to whole quanta.

Top module: `can_bit_timer`

## Requirements
- R1: After hardware reset, `reset_mode` is 1, `cfg_q` is 0000h, `bit_start` and `sample_stb` are 0, and `sample_val` is 1 (recessive).
- R2: A `cfg_we` write loads the whole 16-bit `cfg_wdata` into `cfg_q` only when reset mode was set before the write edge. Otherwise `cfg_q` keeps its value. The field layout is: bits 5:0 prescaler P, bits 7:6 jump field J, bits 11:8 phase-1 field A, bits 14:12 phase-2 field B, bit 15 triple-sample enable T.
- R3: `bus_off` high sets reset mode and overrides a same-cycle `mode_we` with `mode_wdata`=0. Otherwise `mode_we` loads `mode_wdata` into reset mode (1 = reset mode, 0 = operating).
- R4: In operating mode a quantum is P+1 clocks long. The first quantum ends P+1 clocks after the edge that cleared reset mode. `rx` is taken at the clock edge that ends each quantum.
- R5: With no edges, a bit lasts 1+(A+1)+(B+1) quanta. `bit_start` is high in the cycle after a synchronization quantum ends. `sample_stb` is high in the cycle after the last phase-1 quantum ends, with `sample_val` holding the sampled value.
- R6: In idle, a falling edge seen in a quantum makes that quantum the synchronization segment of a new bit (hard synchronization).
- R7: A falling edge in phase 1 at quantum index q (0-based) lengthens phase 1 by min(q+1, J+1) quanta.
- R8: A falling edge in phase 2 with e quanta left in phase 2, the edge quantum included, does one of two things. If e ≤ J+1, the edge quantum becomes the synchronization segment of the next bit. Otherwise phase 2 is shortened by J+1 quanta.
- R9: At most one resynchronization takes place between sample points, and a hard synchronization uses up that allowance. An edge in the synchronization segment changes nothing.
- R10: With T=1 the sampled value is the majority of `rx` over the last three quanta up to the sample point. With T=0 it is `rx` of the last phase-1 quantum.
- R11: After 11 consecutive recessive sample values the unit returns to idle at that sample point and produces no strobes until the next falling edge.
- R12: `bit_start` and `sample_stb` are never high together, and both are 0 from the cycle after reset mode is set for as long as it stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cfg_we | input | 1 | Timing word write strobe |
| cfg_wdata | input | 16 | Timing word write data |
| mode_we | input | 1 | Reset-mode flag write strobe |
| mode_wdata | input | 1 | New reset-mode flag value |
| bus_off | input | 1 | Bus-off indication, forces reset mode |
| rx | input | 1 | Synchronous receive line, 1 = recessive |
| cfg_q | output | 16 | Current timing word |
| reset_mode | output | 1 | Reset-mode flag |
| bit_start | output | 1 | One-cycle strobe at start of bit |
| sample_stb | output | 1 | One-cycle strobe at the sample point |
| sample_val | output | 1 | Last sampled bit value |

## Verification
The bench builds the unit with its default field widths: a 6-bit prescaler, 4-bit and 3-bit phase fields, a 2-bit jump field and an 11-bit idle threshold. It then reprograms the timing word at run time over many configurations. Small prescaler values keep each quantum short, so hundreds of bits per configuration fit in the run. Phase fields of zero combined with the largest jump width reach the cases where the jump exceeds the segment. Long recessive stretches, timed to the programmed bit length, reach the return to idle and the hard synchronization that follows.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
    typedef enum logic [1:0] {
        SEG_IDLE = 2'd0,
        SEG_SYNC = 2'd1,
        SEG_PH1  = 2'd2,
        SEG_PH2  = 2'd3
    } seg_e;
endpackage

// File: rtl/cbt_cfg_regs.sv
module cbt_cfg_regs #(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             mode_we,
    input  logic             mode_wdata,
    input  logic             bus_off,
    output logic [REG_W-1:0] cfg_q,
    output logic             reset_mode
);
    typedef struct packed {
        logic [REG_W-1:0] cfg;
        logic             rmode;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we && st_q.rmode) begin
            st_d.cfg = cfg_wdata;
        end
        if (mode_we) begin
            st_d.rmode = mode_wdata;
        end
        if (bus_off) begin
            st_d.rmode = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cfg: '0, rmode: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_q      = st_q.cfg;
    assign reset_mode = st_q.rmode;
endmodule

// File: rtl/cbt_quantum_gen.sv
module cbt_quantum_gen #(
    parameter int BRP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [BRP_W-1:0] brp,
    output logic             tick
);
    logic [BRP_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == brp) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + BRP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick = run && (cnt_q == brp);
endmodule

// File: rtl/cbt_vote.sv
module cbt_vote #(
    parameter int TAPS = 3
) (
    input  logic [TAPS-1:0] taps,
    input  logic            triple,
    output logic            value
);
    localparam int CW = $clog2(TAPS + 1);

    logic [CW-1:0] ones;

    always_comb begin
        ones = '0;
        for (int i = 0; i < TAPS; i++) begin
            ones = ones + CW'(taps[i]);
        end
        value = triple ? (ones > CW'(TAPS / 2)) : taps[0];
    end
endmodule

// File: rtl/cbt_seg_fsm.sv
module cbt_seg_fsm
    import cbt_pkg::*;
#(
    parameter int PH1_W     = 4,
    parameter int PH2_W     = 3,
    parameter int SJW_W     = 2,
    parameter int IDLE_BITS = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             rx,
    input  logic             vote,
    input  logic [PH1_W-1:0] ph1,
    input  logic [PH2_W-1:0] ph2,
    input  logic [SJW_W-1:0] sjw,
    output logic [1:0]       hist,
    output logic             bit_start,
    output logic             sample_stb,
    output logic             sample_val
);
    localparam int CNT_W = $clog2((1 << PH1_W) + (1 << SJW_W) + 1);
    localparam int RC_W  = $clog2(IDLE_BITS + 1);

    typedef struct packed {
        seg_e             seg;
        logic [CNT_W-1:0] pos;
        logic [CNT_W-1:0] fin;
        logic             rok;
        logic [1:0]       hist;
        logic [RC_W-1:0]  rcnt;
        logic             bs;
        logic             ss;
        logic             sv;
    } fsm_st_t;

    localparam fsm_st_t ST_RST = '{
        seg: SEG_IDLE, pos: '0, fin: '0, rok: 1'b0, hist: 2'b11,
        rcnt: '0, bs: 1'b0, ss: 1'b0, sv: 1'b1
    };

    fsm_st_t          st_d, st_q;
    logic [CNT_W-1:0] len1_m1, len2_m1, jmp, err, fin_c;
    logic             edge_seen;

    always_comb begin
        len1_m1   = CNT_W'(ph1);
        len2_m1   = CNT_W'(ph2);
        jmp       = CNT_W'(sjw) + CNT_W'(1);
        err       = '0;
        fin_c     = st_q.fin;
        edge_seen = st_q.hist[0] & ~rx;
        st_d      = st_q;
        st_d.bs   = 1'b0;
        st_d.ss   = 1'b0;
        if (!run) begin
            st_d = ST_RST;
        end else if (tick) begin
            st_d.hist = {st_q.hist[0], rx};
            unique case (st_q.seg)
                SEG_IDLE: begin
                    if (edge_seen) begin
                        st_d.bs  = 1'b1;
                        st_d.seg = SEG_PH1;
                        st_d.pos = '0;
                        st_d.fin = len1_m1;
                        st_d.rok = 1'b0;
                    end
                end
                SEG_SYNC: begin
                    st_d.bs  = 1'b1;
                    st_d.seg = SEG_PH1;
                    st_d.pos = '0;
                    st_d.fin = len1_m1;
                end
                SEG_PH1: begin
                    if (edge_seen && st_q.rok) begin
                        err      = st_q.pos + CNT_W'(1);
                        fin_c    = st_q.fin + ((err < jmp) ? err : jmp);
                        st_d.rok = 1'b0;
                    end
                    if (st_q.pos == fin_c) begin
                        st_d.ss  = 1'b1;
                        st_d.sv  = vote;
                        st_d.rok = 1'b1;
                        st_d.seg = SEG_PH2;
                        st_d.pos = '0;
                        st_d.fin = len2_m1;
                        if (vote) begin
                            if (st_q.rcnt == RC_W'(IDLE_BITS - 1)) begin
                                st_d.seg  = SEG_IDLE;
                                st_d.rcnt = '0;
                                st_d.rok  = 1'b0;
                            end else begin
                                st_d.rcnt = st_q.rcnt + RC_W'(1);
                            end
                        end else begin
                            st_d.rcnt = '0;
                        end
                    end else begin
                        st_d.pos = st_q.pos + CNT_W'(1);
                        st_d.fin = fin_c;
                    end
                end
                SEG_PH2: begin
                    err = st_q.fin - st_q.pos + CNT_W'(1);
                    if (edge_seen && st_q.rok) begin
                        st_d.rok = 1'b0;
                        if (err <= jmp) begin
                            st_d.bs  = 1'b1;
                            st_d.seg = SEG_PH1;
                            st_d.pos = '0;
                            st_d.fin = len1_m1;
                        end else begin
                            fin_c = st_q.fin - jmp;
                            if (st_q.pos == fin_c) begin
                                st_d.seg = SEG_SYNC;
                                st_d.pos = '0;
                            end else begin
                                st_d.pos = st_q.pos + CNT_W'(1);
                                st_d.fin = fin_c;
                            end
                        end
                    end else if (st_q.pos == st_q.fin) begin
                        st_d.seg = SEG_SYNC;
                        st_d.pos = '0;
                    end else begin
                        st_d.pos = st_q.pos + CNT_W'(1);
                    end
                end
                default: st_d = ST_RST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign hist       = st_q.hist;
    assign bit_start  = st_q.bs;
    assign sample_stb = st_q.ss;
    assign sample_val = st_q.sv;
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
    parameter int BRP_W     = 6,
    parameter int SJW_W     = 2,
    parameter int PH1_W     = 4,
    parameter int PH2_W     = 3,
    parameter int IDLE_BITS = 11,
    localparam int REG_W    = BRP_W + SJW_W + PH1_W + PH2_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             mode_we,
    input  logic             mode_wdata,
    input  logic             bus_off,
    input  logic             rx,
    output logic [REG_W-1:0] cfg_q,
    output logic             reset_mode,
    output logic             bit_start,
    output logic             sample_stb,
    output logic             sample_val
);
    localparam int SJW_LSB    = BRP_W;
    localparam int PH1_LSB    = SJW_LSB + SJW_W;
    localparam int PH2_LSB    = PH1_LSB + PH1_W;
    localparam int TRIPLE_BIT = PH2_LSB + PH2_W;

    logic       tick;
    logic       vote;
    logic [1:0] hist;

    cbt_cfg_regs #(.REG_W(REG_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .bus_off    (bus_off),
        .cfg_q      (cfg_q),
        .reset_mode (reset_mode)
    );

    cbt_quantum_gen #(.BRP_W(BRP_W)) u_tq (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (!reset_mode),
        .brp   (cfg_q[BRP_W-1:0]),
        .tick  (tick)
    );

    cbt_vote #(.TAPS(3)) u_vote (
        .taps   ({hist, rx}),
        .triple (cfg_q[TRIPLE_BIT]),
        .value  (vote)
    );

    cbt_seg_fsm #(
        .PH1_W     (PH1_W),
        .PH2_W     (PH2_W),
        .SJW_W     (SJW_W),
        .IDLE_BITS (IDLE_BITS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (!reset_mode),
        .tick       (tick),
        .rx         (rx),
        .vote       (vote),
        .ph1        (cfg_q[PH1_LSB +: PH1_W]),
        .ph2        (cfg_q[PH2_LSB +: PH2_W]),
        .sjw        (cfg_q[SJW_LSB +: SJW_W]),
        .hist       (hist),
        .bit_start  (bit_start),
        .sample_stb (sample_stb),
        .sample_val (sample_val)
    );
endmodule

// File: rtl/cbt_checker.sv
module cbt_checker #(
    parameter int REG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_off,
    input logic             reset_mode,
    input logic [REG_W-1:0] cfg_q,
    input logic             bit_start,
    input logic             sample_stb,
    input logic             sample_val
);
    assert_cfg_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !reset_mode |=> $stable(cfg_q));

    assert_busoff_forces_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_off |=> reset_mode);

    assert_sample_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);

    assert_value_held_R10: assert property (@(posedge clk) disable iff (!rst_n || reset_mode)
        !sample_stb |-> $stable(sample_val));

    assert_strobes_apart_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && bit_start));

    assert_quiet_in_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        reset_mode |=> (!sample_stb && !bit_start));
endmodule

bind can_bit_timer cbt_checker #(.REG_W(REG_W)) u_cbt_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_off    (bus_off),
    .reset_mode (reset_mode),
    .cfg_q      (cfg_q),
    .bit_start  (bit_start),
    .sample_stb (sample_stb),
    .sample_val (sample_val)
);

// File: tb/can_bit_timer_test.sv
`timescale 1ns/1ps
module can_bit_timer_test;
    localparam int IDLE_N = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        mode_we = 1'b0;
    logic        mode_wdata = 1'b0;
    logic        bus_off = 1'b0;
    logic        rx = 1'b1;
    logic [15:0] cfg_q;
    logic        reset_mode, bit_start, sample_stb, sample_val;

    int checks = 0;
    int errors = 0;

    int    m_seg, m_pos, m_fin, m_rcnt;
    bit    m_rok;
    logic [1:0] m_hist;
    string m_tag;
    int    c_t1, c_t2, c_sjw, c_brp;
    bit    c_sam;

    always #10 clk = ~clk;

    can_bit_timer uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .mode_we(mode_we), .mode_wdata(mode_wdata), .bus_off(bus_off), .rx(rx),
        .cfg_q(cfg_q), .reset_mode(reset_mode), .bit_start(bit_start),
        .sample_stb(sample_stb), .sample_val(sample_val)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    function automatic logic [15:0] pack_cfg(int t1, int t2, int sjw, int brp, bit sam);
        return {sam, 3'(t2), 4'(t1), 2'(sjw), 6'(brp)};
    endfunction

    function automatic int imin(int a, int b);
        return (a < b) ? a : b;
    endfunction

    task automatic model_reset();
        m_seg = 0; m_pos = 0; m_fin = 0; m_rcnt = 0; m_rok = 0;
        m_hist = 2'b11; m_tag = "R5";
    endtask

    task automatic enter_ph2();
        m_seg = 3; m_pos = 0; m_fin = c_t2;
    endtask

    task automatic enter_ph1();
        m_seg = 2; m_pos = 0; m_fin = c_t1;
    endtask

    // reference step for one quantum, from the requirements
    task automatic model_step(input logic r, output logic bs, output logic ss, output logic sv);
        logic e, v;
        int fin_c, err, jmp;
        jmp = c_sjw + 1;
        bs = 0; ss = 0; sv = 0;
        e = m_hist[0] & ~r;
        v = c_sam ? ((int'(m_hist[1]) + int'(m_hist[0]) + int'(r)) >= 2) : r;
        case (m_seg)
            0: if (e) begin bs = 1; m_tag = "R6"; enter_ph1(); m_rok = 0; end
            1: begin bs = 1; if (e) m_tag = "R9"; enter_ph1(); end
            2: begin
                fin_c = m_fin;
                if (e) begin
                    if (m_rok) begin fin_c = m_fin + imin(m_pos + 1, jmp); m_rok = 0; m_tag = "R7"; end
                    else m_tag = "R9";
                end
                if (m_pos == fin_c) begin
                    ss = 1; sv = v; m_rok = 1;
                    if (c_sam) m_tag = "R10";
                    if (v) begin
                        m_rcnt++;
                        if (m_rcnt == IDLE_N) begin m_seg = 0; m_rcnt = 0; m_rok = 0; m_tag = "R11"; end
                        else enter_ph2();
                    end else begin
                        m_rcnt = 0; enter_ph2();
                    end
                end else begin
                    m_pos++; m_fin = fin_c;
                end
            end
            default: begin
                err = m_fin - m_pos + 1;
                if (e && m_rok) begin
                    m_rok = 0; m_tag = "R8";
                    if (err <= jmp) begin bs = 1; enter_ph1(); end
                    else begin
                        fin_c = m_fin - jmp;
                        if (m_pos == fin_c) begin m_seg = 1; m_pos = 0; end
                        else begin m_pos++; m_fin = fin_c; end
                    end
                end else begin
                    if (e) m_tag = "R9";
                    if (m_pos == m_fin) begin m_seg = 1; m_pos = 0; end
                    else m_pos++;
                end
            end
        endcase
        m_hist = {m_hist[0], r};
    endtask

    // program a configuration and leave reset mode; returns at negedge after the release edge
    task automatic start_cfg(input logic [15:0] w);
        @(negedge clk); rx = 1'b1; mode_we = 1; mode_wdata = 1;
        @(posedge clk); @(negedge clk); mode_we = 0; cfg_we = 1; cfg_wdata = w;
        @(posedge clk); @(negedge clk); cfg_we = 0; mode_we = 1; mode_wdata = 0;
        @(posedge clk); @(negedge clk); mode_we = 0;
    endtask

    task automatic run_cfg(int t1, int t2, int sjw, int brp, bit sam, int nq, bit long_run);
        logic eb, es, ev;
        int run_left;
        logic lvl;
        c_t1 = t1; c_t2 = t2; c_sjw = sjw; c_brp = brp; c_sam = sam;
        start_cfg(pack_cfg(t1, t2, sjw, brp, sam));
        model_reset();
        lvl = 1'b1; run_left = 0;
        for (int q = 0; q < nq; q++) begin
            if (run_left > 0) begin
                lvl = 1'b1; run_left--;
            end else if (long_run && q == nq / 3) begin
                run_left = 12 * (3 + t1 + t2); lvl = 1'b1;
            end else if ($urandom % 4 == 0) begin
                lvl = ~lvl;
            end
            rx = lvl;
            repeat (brp + 1) @(posedge clk);
            @(negedge clk);
            model_step(lvl, eb, es, ev);
            chk(bit_start == eb, (m_tag == "R7" || m_tag == "R10") ? "R5" : m_tag, "bit_start", bit_start, eb);
            chk(sample_stb == es, m_tag, "sample_stb", sample_stb, es);
            if (es) chk(sample_val == ev, c_sam ? "R10" : "R5", "sample_val", sample_val, ev);
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL R4 watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        int cyc, first, gap, pulses;
        void'($urandom(32'd20250125));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(reset_mode == 1'b1, "R1", "reset_mode", reset_mode, 1);
        chk(cfg_q == 16'h0000, "R1", "cfg_q", cfg_q, 0);
        chk(bit_start == 0 && sample_stb == 0, "R1", "strobes", {bit_start, sample_stb}, 0);
        chk(sample_val == 1'b1, "R1", "sample_val", sample_val, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 write accepted in reset mode
        cfg_we = 1; cfg_wdata = 16'hA5C3;
        @(posedge clk); @(negedge clk); cfg_we = 0;
        chk(cfg_q == 16'hA5C3, "R2", "cfg_q after reset-mode write", cfg_q, 16'hA5C3);
        mode_we = 1; mode_wdata = 0;
        @(posedge clk); @(negedge clk); mode_we = 0;
        chk(reset_mode == 1'b0, "R3", "reset_mode after clear", reset_mode, 0);
        cfg_we = 1; cfg_wdata = 16'h1234;
        @(posedge clk); @(negedge clk); cfg_we = 0;
        chk(cfg_q == 16'hA5C3, "R2", "cfg_q after locked write", cfg_q, 16'hA5C3);

        // R3 bus-off, and priority over a clear
        bus_off = 1; mode_we = 1; mode_wdata = 0;
        @(posedge clk); @(negedge clk); bus_off = 0; mode_we = 0;
        chk(reset_mode == 1'b1, "R3", "reset_mode after bus_off with clear", reset_mode, 1);
        pulses = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (bit_start || sample_stb) pulses++;
        end
        chk(pulses == 0, "R12", "strobes in reset mode", pulses, 0);
        mode_we = 1; mode_wdata = 0;
        @(posedge clk); @(negedge clk); mode_wdata = 1;
        chk(reset_mode == 1'b0, "R3", "reset_mode after clear", reset_mode, 0);
        @(posedge clk); @(negedge clk); mode_we = 0;
        chk(reset_mode == 1'b1, "R3", "reset_mode after request", reset_mode, 1);

        // R4 quantum length: hard sync then no edges, bit period in clocks
        start_cfg(pack_cfg(4, 2, 0, 3, 0));
        repeat (8) @(negedge clk);
        rx = 1'b0;
        cyc = 0; first = -1; gap = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk); cyc++;
            if (bit_start) begin
                if (first < 0) first = cyc;
                else begin gap = cyc - first; break; end
            end
        end
        chk(first == 4, "R4", "first bit_start delay", first, 4);
        chk(gap == 36, "R4", "bit period clocks", gap, 36);

        // directed corners, then random configurations
        run_cfg(0, 0, 3, 0, 0, 200, 1);
        run_cfg(0, 0, 3, 1, 1, 200, 0);
        run_cfg(15, 7, 3, 0, 1, 200, 1);
        run_cfg(15, 7, 0, 2, 0, 200, 0);
        run_cfg(1, 1, 1, 0, 1, 200, 1);
        for (int k = 0; k < 20; k++) begin
            run_cfg($urandom % 16, $urandom % 8, $urandom % 4, $urandom % 4,
                    1'($urandom % 2), 150, k[0]);
        end
        report();
    end
endmodule